// File: doc/BRIEF.md
# Four-Lane Block Data Receiver

This block takes one block of payload bytes that a card sends to the host over a 4-bit wide SD data bus. It runs on the bus clock. In high-speed timing the card moves its data lines just after each rising edge, so the block samples the lines on the next rising edge, when the value has settled for nearly a full period. The host arms the receiver with a byte count and a timeout limit. The receiver waits for the lines to idle high and then for the all-low start nibble. It packs the payload nibbles into bytes and streams them out with a one-cycle strobe. It then compares the sixteen trailing check nibbles against four CRC16 remainders that it computes in parallel, and it checks the closing nibble.

When the block is complete, or when the timeout runs out, the receiver pulses a completion strobe. The result flags stay valid from that strobe until the next arm. The CRC result is a 4-bit mask with one bit per data line, so a fault can be traced to a single line.

Top module: `sdio_blk_rx`

## Requirements
- R1: While reset is asserted and after it is released, `byte_vld_o`, `done_o`, `tmo_o`, `end_err_o` are 0 and `crc_err_o` is 4'b0000.
- R2: After an arm, a block starts only on a sampled nibble of 4'h0 that follows at least one sampled nibble of 4'hF since the arm. Nibbles of 4'h0 seen before any 4'hF are not a start.
- R3: Payload nibbles pair into bytes with the first-received nibble in bits [7:4]. `byte_vld_o` is high for one cycle, in the cycle after the second nibble of a pair is sampled, and never in two consecutive cycles.
- R4: Exactly `len_i` bytes (1 to 512, latched at arm) are delivered per block, in bus order.
- R5: For each line l, the receiver computes a CRC16 with generator x^16+x^12+x^5+1 and initial value 0 over that line's payload bits. The card sends it most significant bit first in the 16 nibbles after the payload. `crc_err_o[l]` is 1 exactly when line l's received CRC differs from the computed one.
- R6: `end_err_o` is 1 exactly when the nibble sampled after the 16 CRC nibbles is not 4'hF.
- R7: `done_o` is a one-cycle pulse in the cycle after the end nibble is sampled. `crc_err_o` and `end_err_o` change only at that pulse or in the cycle after an arm.
- R8: With `tmo_i` = N (N >= 1), if no start is accepted on any of the N clocks following the arm clock, `tmo_o` is set and `done_o` pulses in the cycle after the Nth such clock. A start sampled on the Nth clock is accepted.
- R9: `arm_i` is ignored while a block is being waited for or received.
- R10: An accepted arm clears `crc_err_o`, `end_err_o` and `tmo_o` from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start-of-receive strobe, taken only when idle |
| len_i | input | 10 | Payload length in bytes, 1 to 512 |
| tmo_i | input | 16 | Clocks to wait for a start nibble, at least 1 |
| dat_i | input | 4 | The four data lines |
| byte_o | output | 8 | Received byte |
| byte_vld_o | output | 1 | One-cycle strobe qualifying `byte_o` |
| done_o | output | 1 | One-cycle completion strobe |
| crc_err_o | output | 4 | Per-line CRC mismatch mask |
| end_err_o | output | 1 | Closing nibble was not all ones |
| tmo_o | output | 1 | No start nibble arrived in time |

## Verification
The block is driven with random payloads of random length, with random idle gaps before the start. Some runs put leading all-low nibbles before any idle-high nibble, which separates a correct idle-then-start detector from one that takes the first zero nibble. CRC faults are injected as flips on chosen lines, one line or several, so a wrong line mapping in the mask shows up. Corrupted closing nibbles, arms pulsed in mid-block, a single-byte block and a 512-byte block cover the framing and counting limits. The timeout is tried both with no start at all and with a start on exactly the last allowed clock, which pins down the off-by-one edge of the window.

// File: rtl/sdio_rx_pkg.sv
package sdio_rx_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_GEN = 16'h1021;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_WAIT,
    RX_PAY,
    RX_CRC,
    RX_END
  } rx_state_e;
endpackage

// File: rtl/sdio_crc16x4.sv
module sdio_crc16x4
  import sdio_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             shift,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] top
);
  // storage interleaved: rem_q[k][l] is bit k of lane l's remainder
  logic [CRC_W-1:0][LANES-1:0] rem_q, rem_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic fb;
    assign fb     = d[l] ^ rem_q[CRC_W-1][l];
    assign top[l] = rem_q[CRC_W-1][l];
    always_comb begin
      for (int k = 0; k < CRC_W; k++) begin
        if (clr)
          rem_d[k][l] = 1'b0;
        else if (upd)
          rem_d[k][l] = (k == 0) ? fb : (rem_q[k-1][l] ^ (CRC_GEN[k] & fb));
        else if (shift)
          rem_d[k][l] = (k == 0) ? 1'b0 : rem_q[k-1][l];
        else
          rem_d[k][l] = rem_q[k][l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end
endmodule

// File: rtl/sdio_nib_pack.sv
module sdio_nib_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [3:0] d,
  output logic [7:0] byte_o,
  output logic       vld_o
);
  logic       ph_q, ph_d;
  logic [3:0] hi_q, hi_d;
  logic [7:0] by_q, by_d;
  logic       vld_q, vld_d;

  always_comb begin
    ph_d  = ph_q;
    hi_d  = hi_q;
    by_d  = by_q;
    vld_d = 1'b0;
    if (clr) begin
      ph_d = 1'b0;
    end else if (en) begin
      if (!ph_q) begin
        hi_d = d;
        ph_d = 1'b1;
      end else begin
        by_d  = {hi_q, d};
        vld_d = 1'b1;
        ph_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      hi_q  <= '0;
      by_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      hi_q  <= hi_d;
      by_q  <= by_d;
      vld_q <= vld_d;
    end
  end

  assign byte_o = by_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/sdio_blk_rx.sv
module sdio_blk_rx
  import sdio_rx_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 512,
  parameter int unsigned LEN_W     = $clog2(MAX_BYTES + 1),
  parameter int unsigned TMO_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic [3:0]       dat_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             done_o,
  output logic [3:0]       crc_err_o,
  output logic             end_err_o,
  output logic             tmo_o
);
  localparam int unsigned NIB_W = LEN_W + 1;
  localparam logic [NIB_W-1:0] CRC_LAST = NIB_W'(CRC_W - 1);

  rx_state_e        st_q, st_d;
  logic [TMO_W-1:0] tcnt_q, tcnt_d, tlim_q, tlim_d;
  logic [NIB_W-1:0] ncnt_q, ncnt_d, nlast_q, nlast_d;
  logic             seen_q, seen_d;
  logic [3:0]       mis_q, mis_d, cerr_q, cerr_d;
  logic             eerr_q, eerr_d, tmo_q, tmo_d, done_q, done_d;
  logic             c_clr, c_upd, c_sh, p_clr, p_en;
  logic [3:0]       c_top;

  sdio_crc16x4 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(c_clr), .upd(c_upd), .shift(c_sh),
    .d(dat_i), .top(c_top)
  );

  sdio_nib_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clr(p_clr), .en(p_en), .d(dat_i),
    .byte_o(byte_o), .vld_o(byte_vld_o)
  );

  always_comb begin
    st_d    = st_q;
    tcnt_d  = tcnt_q;
    tlim_d  = tlim_q;
    ncnt_d  = ncnt_q;
    nlast_d = nlast_q;
    seen_d  = seen_q;
    mis_d   = mis_q;
    cerr_d  = cerr_q;
    eerr_d  = eerr_q;
    tmo_d   = tmo_q;
    done_d  = 1'b0;
    c_clr   = 1'b0;
    c_upd   = 1'b0;
    c_sh    = 1'b0;
    p_clr   = 1'b0;
    p_en    = 1'b0;
    unique case (st_q)
      RX_IDLE: if (arm_i) begin
        st_d    = RX_WAIT;
        tcnt_d  = '0;
        tlim_d  = tmo_i;
        nlast_d = {len_i, 1'b0} - NIB_W'(1);
        seen_d  = 1'b0;
        mis_d   = '0;
        cerr_d  = '0;
        eerr_d  = 1'b0;
        tmo_d   = 1'b0;
        c_clr   = 1'b1;
        p_clr   = 1'b1;
      end
      RX_WAIT: begin
        if (seen_q && dat_i == 4'h0) begin
          st_d   = RX_PAY;
          ncnt_d = '0;
        end else if (tcnt_q == tlim_q - TMO_W'(1)) begin
          st_d   = RX_IDLE;
          tmo_d  = 1'b1;
          done_d = 1'b1;
        end else begin
          tcnt_d = tcnt_q + TMO_W'(1);
          if (dat_i == 4'hF) seen_d = 1'b1;
        end
      end
      RX_PAY: begin
        c_upd = 1'b1;
        p_en  = 1'b1;
        if (ncnt_q == nlast_q) begin
          st_d   = RX_CRC;
          ncnt_d = '0;
        end else begin
          ncnt_d = ncnt_q + NIB_W'(1);
        end
      end
      RX_CRC: begin
        c_sh  = 1'b1;
        mis_d = mis_q | (dat_i ^ c_top);
        if (ncnt_q == CRC_LAST) st_d = RX_END;
        else                    ncnt_d = ncnt_q + NIB_W'(1);
      end
      RX_END: begin
        st_d   = RX_IDLE;
        cerr_d = mis_q;
        eerr_d = (dat_i != 4'hF);
        done_d = 1'b1;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      tcnt_q  <= '0;
      tlim_q  <= '0;
      ncnt_q  <= '0;
      nlast_q <= '0;
      seen_q  <= 1'b0;
      mis_q   <= '0;
      cerr_q  <= '0;
      eerr_q  <= 1'b0;
      tmo_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      tcnt_q  <= tcnt_d;
      tlim_q  <= tlim_d;
      ncnt_q  <= ncnt_d;
      nlast_q <= nlast_d;
      seen_q  <= seen_d;
      mis_q   <= mis_d;
      cerr_q  <= cerr_d;
      eerr_q  <= eerr_d;
      tmo_q   <= tmo_d;
      done_q  <= done_d;
    end
  end

  assign done_o    = done_q;
  assign crc_err_o = cerr_q;
  assign end_err_o = eerr_q;
  assign tmo_o     = tmo_q;
endmodule

// File: rtl/sdio_blk_rx_chk.sv
module sdio_blk_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arm_i,
  input logic       byte_vld_o,
  input logic       done_o,
  input logic [3:0] crc_err_o,
  input logic       end_err_o,
  input logic       tmo_o
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_vld_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);

  p_vld_not_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld_o && done_o));

  p_tmo_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_o) |-> done_o);

  p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(arm_i) && !done_o) |-> $stable(crc_err_o));

  p_end_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(arm_i) && !done_o) |-> $stable(end_err_o));
endmodule

bind sdio_blk_rx sdio_blk_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .byte_vld_o(byte_vld_o),
  .done_o(done_o), .crc_err_o(crc_err_o), .end_err_o(end_err_o), .tmo_o(tmo_o)
);

// File: tb/sim_sdio_blk_rx.sv
`timescale 1ns/1ps
module sim_sdio_blk_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm_i = 1'b0;
  logic [9:0] len_i = '0;
  logic [15:0] tmo_i = 16'd1000;
  logic [3:0] dat_i = 4'hF;
  logic [7:0] byte_o;
  logic       byte_vld_o, done_o, end_err_o, tmo_o;
  logic [3:0] crc_err_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] tx_b [0:511];
  logic [7:0] rx_b [0:511];
  int rx_n = 0;

  always #5 clk = ~clk;

  sdio_blk_rx u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .len_i(len_i), .tmo_i(tmo_i),
    .dat_i(dat_i), .byte_o(byte_o), .byte_vld_o(byte_vld_o), .done_o(done_o),
    .crc_err_o(crc_err_o), .end_err_o(end_err_o), .tmo_o(tmo_o)
  );

  always @(negedge clk)
    if (rst_n && byte_vld_o && rx_n < 512) begin
      rx_b[rx_n] = byte_o;
      rx_n++;
    end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-line CRC16 of the payload, serial model from the generator polynomial
  function automatic logic [15:0] line_crc(input int nbytes, input int l);
    logic [15:0] c = '0;
    for (int i = 0; i < 2 * nbytes; i++) begin
      logic [3:0] nb = (i % 2 == 0) ? tx_b[i/2][7:4] : tx_b[i/2][3:0];
      logic fb = nb[l] ^ c[15];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic do_arm(input int len, input int tmo);
    rx_n = 0;
    @(posedge clk); #1;
    len_i = 10'(len); tmo_i = 16'(tmo); arm_i = 1'b1;
    @(posedge clk); #1;
    arm_i = 1'b0;
  endtask

  task automatic drive(input logic [3:0] v, input logic a);
    dat_i = v; arm_i = a;
    @(posedge clk); #1;
    arm_i = 1'b0;
  endtask

  // crc_flip: lines to corrupt in CRC nibble 5; mid_arm: payload nibble index to pulse arm on, -1 none
  task automatic run_block(input int len, input int zeros, input int idles,
                           input logic [3:0] crc_flip, input logic [3:0] end_nib,
                           input int mid_arm, input int tmo, input string tag);
    logic [15:0] crc [4];
    int bad_i;
    for (int l = 0; l < 4; l++) crc[l] = line_crc(len, l);
    do_arm(len, tmo);
    check({tag, " R10 flags cleared"}, {crc_err_o, end_err_o, tmo_o}, 0);
    for (int i = 0; i < zeros; i++) drive(4'h0, 1'b0);
    for (int i = 0; i < idles; i++) drive(4'hF, 1'b0);
    drive(4'h0, 1'b0);
    for (int i = 0; i < 2 * len; i++)
      drive((i % 2 == 0) ? tx_b[i/2][7:4] : tx_b[i/2][3:0], i == mid_arm);
    for (int k = 15; k >= 0; k--) begin
      logic [3:0] n;
      for (int l = 0; l < 4; l++) n[l] = crc[l][k];
      if (k == 10) n = n ^ crc_flip;
      drive(n, 1'b0);
    end
    drive(end_nib, 1'b0);
    dat_i = 4'hF;
    #3;
    check({tag, " R7 done pulse"}, done_o, 1);
    check({tag, " R5 crc mask"}, crc_err_o, crc_flip);
    check({tag, " R6 end flag"}, end_err_o, end_nib != 4'hF);
    check({tag, " R8 no timeout"}, tmo_o, 0);
    check({tag, " R4 byte count"}, rx_n, len);
    bad_i = -1;
    for (int i = 0; i < len && i < rx_n; i++)
      if (bad_i < 0 && rx_b[i] !== tx_b[i]) bad_i = i;
    if (bad_i >= 0) check({tag, " R3 byte value"}, rx_b[bad_i], tx_b[bad_i]);
    else            check({tag, " R3 byte value"}, 0, 0);
    @(posedge clk); #4;
    check({tag, " R7 done one cycle"}, done_o, 0);
  endtask

  task automatic fill(input int len);
    for (int i = 0; i < len; i++) tx_b[i] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5D1C));
    #1;
    check("R1 reset outputs", {byte_vld_o, done_o, tmo_o, end_err_o, crc_err_o}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #4;
    check("R1 after release", {byte_vld_o, done_o, tmo_o, end_err_o, crc_err_o}, 0);

    // directed: known 4-byte block
    tx_b[0] = 8'hA6; tx_b[1] = 8'hA9; tx_b[2] = 8'h41; tx_b[3] = 8'h15;
    run_block(4, 0, 1, 4'h0, 4'hF, -1, 1000, "dir4");
    // R2: leading zeros before idle high must not start
    fill(6);
    run_block(6, 3, 2, 4'h0, 4'hF, -1, 1000, "R2 zeros");
    // R5 single line faults, each lane
    for (int l = 0; l < 4; l++) begin
      fill(5);
      run_block(5, 0, 1, 4'(1 << l), 4'hF, -1, 1000, "R5 lane");
    end
    fill(3);
    run_block(3, 0, 2, 4'hA, 4'h7, -1, 1000, "R5 R6 multi");
    // R9 arm mid block
    fill(8);
    run_block(8, 0, 1, 4'h0, 4'hF, 5, 1000, "R9 mid arm");
    // R10 after error block: next block clears flags (checked in run_block)
    fill(1);
    run_block(1, 0, 1, 4'h0, 4'hF, -1, 1000, "R4 one byte");
    fill(512);
    run_block(512, 0, 1, 4'h0, 4'hF, -1, 1000, "R4 max");
    // R8 start accepted on last allowed clock
    fill(2);
    run_block(2, 0, 6, 4'h0, 4'hF, -1, 7, "R8 edge start");

    // R8 timeout with no start
    do_arm(4, 9);
    dat_i = 4'hF;
    for (int i = 1; i <= 9; i++) begin
      @(posedge clk); #4;
      if (i < 9) check("R8 no early done", done_o, 0);
      else check("R8 timeout", {done_o, tmo_o}, 2'b11);
    end
    @(posedge clk); #4;
    check("R8 tmo held", tmo_o, 1);

    // random blocks
    for (int t = 0; t < 30; t++) begin
      int len = 1 + int'($urandom % 64);
      logic [3:0] fl = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      logic [3:0] en = ($urandom % 4 == 0) ? 4'($urandom % 15) : 4'hF;
      fill(len);
      run_block(len, int'($urandom % 3), 1 + int'($urandom % 4), fl, en,
                -1, 1000, "rand R3 R4 R5 R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule